// File: doc/BRIEF.md
# Byte-Wide UV-Erasable PROM Emulator

This block stands in for a byte-wide, UV-erasable or one-time-programmable read-only memory inside an FPGA test fixture. A host or a device under test drives address, data and the active-low select, output-gate and program-strobe pins. Two flags replace the analog levels: one says the programming supply is raised, the other says the high identifier voltage is present on address line 9. From these the block picks its operating mode every clock. It then drives the stored byte, drives an identifier byte, releases the bus, or burns a byte.

Burning follows the physics of the cell. A bit can only fall from 1 to 0, so a program pulse ANDs the input data into the stored byte. An erase input returns the whole array to all ones, and reset does the same, so the fixture starts from a blank part. The bus is split into an input byte, an output byte and an output-enable, and the output-enable low means the pins are high-impedance. All inputs are sampled on the clock. Outputs are registered, so they follow the inputs one clock later.

The array holds 2^MEM_AW bytes. Setting MEM_AW to 17 gives the full 131,072 x 8 part. The default of 11 keeps elaboration small, and with it the unused high address bits alias.

Top module: `eprom_emu`

## Requirements
- R1: After reset, and also during reset, dout_en is 0. After reset every byte reads 8'hFF.
- R2: Read mode drives the stored byte with dout_en = 1 one clock after the inputs are sampled. Read mode is chip_sel_n = 0, out_en_n = 0, vpp_hi = 0 and a9_hi = 0, with pgm_n don't-care.
- R3: With chip_sel_n = 1, dout_en is 0 whatever the other inputs are. This covers standby and program inhibit.
- R4: With chip_sel_n = 0, out_en_n = 1 and vpp_hi = 0, dout_en is 0.
- R5: A program pulse stores old & din at the addressed byte, once, on the clock where pgm_n is seen high after being seen low. The pulse counts only when vpp_hi = 1, chip_sel_n = 0, out_en_n = 1 and a9_hi = 0 hold in both the low cycle and the rising cycle. Bits are never set by programming.
- R6: A strobe pulse writes nothing in two cases: while chip_sel_n = 1, or when its low phase was seen outside the program conditions.
- R7: Verify mode drives the stored byte with dout_en = 1. Verify mode is vpp_hi = 1, chip_sel_n = 0, out_en_n = 0, pgm_n = 1 and a9_hi = 0.
- R8: Signature mode drives 8'h20 when addr[0] = 0 and 8'h05 when addr[0] = 1, with dout_en = 1. Signature mode is a9_hi = 1, vpp_hi = 0, chip_sel_n = 0, out_en_n = 0 and pgm_n = 1.
- R9: Every other input combination gives dout_en = 0 and writes nothing. Examples are a9_hi = 1 outside signature mode, and vpp_hi = 1 with out_en_n = 0 and pgm_n = 0.
- R10: A clock with erase = 1 leaves every byte reading 8'hFF. Erase wins over a program pulse in the same clock.
- R11: Only addr[MEM_AW-1:0] selects a byte. With the default MEM_AW = 11, address 0x00810 reads the same byte as 0x00010.
- R12: Whenever dout_en is 0, dout is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixture clock |
| rst_n | input | 1 | Asynchronous active-low reset; restores the blank array |
| erase | input | 1 | Synchronous whole-array erase to all ones |
| addr | input | 17 | Byte address |
| chip_sel_n | input | 1 | Active-low device select |
| out_en_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low program strobe |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hi | input | 1 | Identifier voltage present on address line 9 |
| din | input | 8 | Data to burn |
| dout | output | 8 | Data driven to the bus |
| dout_en | output | 1 | Bus driven; 0 means high-impedance |

## Verification
The assertions take for granted that all pins are synchronous to clk. They also assume the address is held steady across a program pulse and in the clock after it, because the bit-only-falls check reads the byte back at the same index. The stimulus table changes inputs only between clock edges. Each strobe is built as one low vector followed by one high vector at an unchanged address and data. Erase and reset are applied only from directed steps at chosen points, so no check depends on two events sharing an edge, except the deliberate erase-versus-pulse case.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  // operating mode chosen from the control pins each clock
  typedef enum logic [2:0] {
    MD_HIZ    = 3'd0,
    MD_READ   = 3'd1,
    MD_VERIFY = 3'd2,
    MD_SIG    = 3'd3,
    MD_PROG   = 3'd4
  } eprom_mode_e;

  localparam logic [7:0] ID_MAKER = 8'h20;
  localparam logic [7:0] ID_PART  = 8'h05;

endpackage

// File: rtl/eprom_rst_sync.sv
module eprom_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic        chip_sel_n,
  input  logic        out_en_n,
  input  logic        pgm_n,
  input  logic        vpp_hi,
  input  logic        a9_hi,
  output eprom_mode_e mode,
  output logic        prog_cond
);

  always_comb begin
    mode      = MD_HIZ;
    prog_cond = 1'b0;
    if (!chip_sel_n) begin
      if (a9_hi) begin
        if (!vpp_hi && !out_en_n && pgm_n) mode = MD_SIG;
      end else if (!vpp_hi) begin
        if (!out_en_n) mode = MD_READ;
      end else begin
        if (!out_en_n && pgm_n) begin
          mode = MD_VERIFY;
        end else if (out_en_n) begin
          mode      = MD_PROG;
          prog_cond = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pgm_n,
  input  logic prog_cond,
  input  logic erase,
  output logic wr_en
);

  logic armed_q;
  logic armed_d;
  logic armed_ce;

  // armed while the strobe is low under program conditions
  always_comb begin
    armed_ce = 1'b1;
    armed_d  = !pgm_n && prog_cond;
    wr_en    = pgm_n && armed_q && prog_cond && !erase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_ce) armed_q <= armed_d;
  end

  // R5: one write per pulse
  p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R5: a write follows a low strobe sample
  p_low_before_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(!pgm_n));

  // R6: the low phase must itself have been under program conditions
  p_armed_in_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(prog_cond));

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int MEM_AW = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] idx,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_byte
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  burned_q;
  logic [DEPTH-1:0]  burned_d;
  logic [DATA_W-1:0] merged;

  // a byte never burned since the last erase reads as all ones
  always_comb begin
    rd_byte = burned_q[idx] ? mem[idx] : {DATA_W{1'b1}};
    merged  = rd_byte & din;
  end

  always_comb begin
    burned_d = burned_q;
    if (erase)      burned_d = '0;
    else if (wr_en) burned_d[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burned_q <= '0;
    else        burned_q <= burned_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= merged;
  end

  // R10: erase leaves every byte blank
  p_erase_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (rd_byte == {DATA_W{1'b1}}));

  // R5: bits cleared by the data are clear afterwards
  p_zeros_stick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en ##1 (idx == $past(idx)) |-> ((rd_byte & ~$past(din)) == '0));

  // R5: programming never raises a bit
  p_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en ##1 (idx == $past(idx)) |-> ((rd_byte & ~$past(rd_byte)) == '0));

endmodule

// File: rtl/eprom_emu.sv
module eprom_emu
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              a9_hi,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic              rst_s;
  eprom_mode_e       mode;
  logic              prog_cond;
  logic              wr_en;
  logic [MEM_AW-1:0] idx;
  logic [DATA_W-1:0] rd_byte;
  logic [DATA_W-1:0] dout_d;
  logic              dout_en_d;
  logic [DATA_W-1:0] dout_q;
  logic              dout_en_q;

  eprom_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  // array index; upper bits alias when the array is shallower than the bus
  assign idx = addr[MEM_AW-1:0];
  generate
    if (MEM_AW < ADDR_W) begin : g_alias
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr[ADDR_W-1:MEM_AW];
    end
  endgenerate

  eprom_mode_dec u_dec (
    .chip_sel_n (chip_sel_n),
    .out_en_n   (out_en_n),
    .pgm_n      (pgm_n),
    .vpp_hi     (vpp_hi),
    .a9_hi      (a9_hi),
    .mode       (mode),
    .prog_cond  (prog_cond)
  );

  eprom_prog_ctrl u_prog (
    .clk       (clk),
    .rst_n     (rst_s),
    .pgm_n     (pgm_n),
    .prog_cond (prog_cond),
    .erase     (erase),
    .wr_en     (wr_en)
  );

  eprom_array #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_s),
    .erase   (erase),
    .wr_en   (wr_en),
    .idx     (idx),
    .din     (din),
    .rd_byte (rd_byte)
  );

  always_comb begin
    dout_d    = '0;
    dout_en_d = 1'b0;
    unique case (mode)
      MD_READ, MD_VERIFY: begin
        dout_d    = rd_byte;
        dout_en_d = 1'b1;
      end
      MD_SIG: begin
        dout_d    = addr[0] ? DATA_W'(ID_PART) : DATA_W'(ID_MAKER);
        dout_en_d = 1'b1;
      end
      default: begin
        dout_d    = '0;
        dout_en_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      dout_q    <= '0;
      dout_en_q <= 1'b0;
    end else begin
      dout_q    <= dout_d;
      dout_en_q <= dout_en_d;
    end
  end

  assign dout    = dout_q;
  assign dout_en = dout_en_q;

  // R3: a deselected part never drives the bus
  p_deselect_hiz_r3: assert property (@(posedge clk) disable iff (!rst_s)
    $past(chip_sel_n) |-> !dout_en);

  // R2: driving requires the output gate low in the sampled cycle
  p_gate_low_r2: assert property (@(posedge clk) disable iff (!rst_s)
    dout_en |-> $past(!out_en_n));

  // R12: a released bus carries zero
  p_quiet_bus_r12: assert property (@(posedge clk) disable iff (!rst_s)
    !dout_en |-> (dout == '0));

  // R8: the identifier follows address bit 0
  p_sig_code_r8: assert property (@(posedge clk) disable iff (!rst_s)
    $past(mode == MD_SIG) |-> (dout == ($past(addr[0]) ? 8'h05 : 8'h20)));

endmodule

// File: tb/test_eprom_emu.sv
module test_eprom_emu;

  typedef struct packed {
    logic        vpp;
    logic        a9;
    logic        ce_n;
    logic        oe_n;
    logic        pg_n;
    logic [16:0] ad;
    logic [7:0]  di;
    logic        x_en;
    logic [7:0]  x_do;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b1,17'h00010,8'h00,1'b1,8'hFF}, // 0  R1 blank
    '{1'b0,1'b0,1'b0,1'b0,1'b1,17'h1FFFF,8'h00,1'b1,8'hFF}, // 1  R1 blank
    '{1'b0,1'b0,1'b1,1'b0,1'b1,17'h00010,8'h00,1'b0,8'h00}, // 2  R3 standby
    '{1'b0,1'b0,1'b0,1'b1,1'b1,17'h00010,8'h00,1'b0,8'h00}, // 3  R4 disable
    '{1'b0,1'b1,1'b0,1'b0,1'b1,17'h00000,8'h00,1'b1,8'h20}, // 4  R8 maker
    '{1'b0,1'b1,1'b0,1'b0,1'b1,17'h00001,8'h00,1'b1,8'h05}, // 5  R8 part
    '{1'b1,1'b0,1'b0,1'b1,1'b0,17'h00010,8'hA5,1'b0,8'h00}, // 6  R5 strobe low
    '{1'b1,1'b0,1'b0,1'b1,1'b1,17'h00010,8'hA5,1'b0,8'h00}, // 7  R5 strobe rise
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00010,8'h00,1'b1,8'hA5}, // 8  R7 verify
    '{1'b0,1'b0,1'b0,1'b0,1'b0,17'h00010,8'h00,1'b1,8'hA5}, // 9  R2 read
    '{1'b1,1'b0,1'b0,1'b1,1'b0,17'h00010,8'h3C,1'b0,8'h00}, // 10 R5 second pulse
    '{1'b1,1'b0,1'b0,1'b1,1'b1,17'h00010,8'h3C,1'b0,8'h00}, // 11 R5 rise
    '{1'b0,1'b0,1'b0,1'b0,1'b1,17'h00010,8'h00,1'b1,8'h24}, // 12 R5 AND merge
    '{1'b1,1'b0,1'b0,1'b1,1'b1,17'h00010,8'h00,1'b0,8'h00}, // 13 R5 held high
    '{1'b0,1'b0,1'b0,1'b0,1'b1,17'h00010,8'h00,1'b1,8'h24}, // 14 R5 once only
    '{1'b1,1'b0,1'b1,1'b1,1'b0,17'h00020,8'h00,1'b0,8'h00}, // 15 R6 inhibit low
    '{1'b1,1'b0,1'b1,1'b1,1'b1,17'h00020,8'h00,1'b0,8'h00}, // 16 R6 inhibit rise
    '{1'b0,1'b0,1'b0,1'b0,1'b1,17'h00020,8'h00,1'b1,8'hFF}, // 17 R6 untouched
    '{1'b1,1'b1,1'b0,1'b1,1'b0,17'h00030,8'h00,1'b0,8'h00}, // 18 R9 a9 + prog
    '{1'b1,1'b1,1'b0,1'b1,1'b1,17'h00030,8'h00,1'b0,8'h00}, // 19 R9 rise
    '{1'b0,1'b0,1'b0,1'b0,1'b1,17'h00030,8'h00,1'b1,8'hFF}, // 20 R9 untouched
    '{1'b1,1'b0,1'b0,1'b0,1'b0,17'h00010,8'h00,1'b0,8'h00}, // 21 R9 verify strobe low
    '{1'b0,1'b1,1'b0,1'b0,1'b0,17'h00000,8'h00,1'b0,8'h00}, // 22 R9 sig strobe low
    '{1'b0,1'b1,1'b0,1'b1,1'b1,17'h00000,8'h00,1'b0,8'h00}, // 23 R9 sig gate high
    '{1'b0,1'b0,1'b0,1'b0,1'b1,17'h00810,8'h00,1'b1,8'h24}, // 24 R11 alias
    '{1'b0,1'b0,1'b0,1'b1,1'b0,17'h00040,8'h00,1'b0,8'h00}, // 25 R6 low w/o supply
    '{1'b1,1'b0,1'b0,1'b1,1'b1,17'h00040,8'h00,1'b0,8'h00}, // 26 R6 rise
    '{1'b0,1'b0,1'b0,1'b0,1'b1,17'h00040,8'h00,1'b1,8'hFF}, // 27 R6 untouched
    '{1'b0,1'b0,1'b0,1'b0,1'b1,17'h00011,8'h00,1'b1,8'hFF}  // 28 R2 neighbour
  };

  logic        clk;
  logic        rst_n;
  logic        erase;
  logic [16:0] addr;
  logic        chip_sel_n;
  logic        out_en_n;
  logic        pgm_n;
  logic        vpp_hi;
  logic        a9_hi;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        dout_en;

  int n_chk;
  int n_bad;
  bit done;

  eprom_emu i_eprom_emu (
    .clk        (clk),
    .rst_n      (rst_n),
    .erase      (erase),
    .addr       (addr),
    .chip_sel_n (chip_sel_n),
    .out_en_n   (out_en_n),
    .pgm_n      (pgm_n),
    .vpp_hi     (vpp_hi),
    .a9_hi      (a9_hi),
    .din        (din),
    .dout       (dout),
    .dout_en    (dout_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic drive(input logic v, input logic a, input logic c, input logic o,
                       input logic p, input logic [16:0] ad, input logic [7:0] d);
    vpp_hi = v; a9_hi = a; chip_sel_n = c; out_en_n = o; pgm_n = p;
    addr = ad; din = d;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic xe, input logic [7:0] xd);
    n_chk++;
    if (dout_en !== xe || dout !== xd) begin
      n_bad++;
      $display("FAIL %s: got en=%0b data=%02h, expected en=%0b data=%02h",
               req, dout_en, dout, xe, xd);
    end
  endtask

  task automatic burn(input logic [16:0] ad, input logic [7:0] d);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, ad, d); step();
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, ad, d); step();
  endtask

  task automatic read_at(input logic [16:0] ad);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, ad, 8'h00); step();
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    erase = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 17'h0, 8'h0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 8'h00);
    rst_n = 1'b1;
    repeat (4) step();

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].vpp, VEC[i].a9, VEC[i].ce_n, VEC[i].oe_n, VEC[i].pg_n,
            VEC[i].ad, VEC[i].di);
      step();
      check($sformatf("vector %0d", i), VEC[i].x_en, VEC[i].x_do);
    end

    // R5: clear a byte fully
    burn(17'h00050, 8'h00);
    read_at(17'h00050);
    check("R5 full clear", 1'b1, 8'h00);

    // R10: erase in the same clock as a strobe rise
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 17'h00060, 8'h00); step();
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 17'h00060, 8'h00);
    erase = 1'b1; step();
    erase = 1'b0;
    read_at(17'h00060);
    check("R10 erase beats pulse", 1'b1, 8'hFF);
    read_at(17'h00050);
    check("R10 erased byte", 1'b1, 8'hFF);
    read_at(17'h00010);
    check("R10 erased merged byte", 1'b1, 8'hFF);

    // R1: reset mid-run blanks the array
    burn(17'h00070, 8'h11);
    read_at(17'h00070);
    check("R2 after burn", 1'b1, 8'h11);
    rst_n = 1'b0;
    #1;
    check("R1 reset releases bus", 1'b0, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 read after reset", 1'b1, 8'hFF);

    // R12 / R3: deselect after a driving cycle
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 17'h00070, 8'h00); step();
    check("R3 R12 deselect", 1'b0, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule